// File: doc/BRIEF.md
# Tile RAM Interleave and ROM Readthrough Mapper

This block sits between a 16-bit host bus and a tile RAM addressed by a flat word index. The host reaches the RAM through two 4096-word windows, a primary and a mirror. Each window is cut into a lower and an upper half. One half lands on the odd RAM words and the other half lands on the even RAM words. The mirror window swaps that parity, so the same RAM word can be reached under two different host offsets.

A third window lets the host read a byte-wide graphics ROM as 16-bit words. The bank is held in a small video register file. A half-select control input adds a further offset. A legacy input turns the interleave off, so that both RAM windows map each word offset onto the same RAM word.

Each host access is acknowledged in the cycle it is presented. Read data from RAM, ROM or the unmapped window comes back one cycle later, with a valid strobe.

Top module: `tile_map_top`

## Requirements
- R1: With legacy_i low and win_i = 0 (primary), a word offset below 0x800 accesses RAM word offset*2+1, and an offset of 0x800 or more accesses RAM word (offset-0x800)*2.
- R2: With legacy_i low and win_i = 1 (mirror), a word offset below 0x800 accesses RAM word offset*2, and an offset of 0x800 or more accesses RAM word (offset-0x800)*2+1.
- R3: The half boundaries map exactly as follows. Primary 0x7FF goes to word 0xFFF, primary 0xFFF goes to word 0xFFE, mirror 0x7FF goes to word 0xFFE, and mirror 0x800 goes to word 1.
- R4: Reads and writes use the same mapping. The byte strobes pass through unchanged: be_i bit 0 enables data bits 7:0 and be_i bit 1 enables data bits 15:8. The write data also passes through unchanged.
- R5: ack_o is high in the same cycle as req_i. A read raises rvalid_o, with its data on rdata_o, exactly one cycle later. A write raises no rvalid_o.
- R6: A video register write to byte offset 0x34 loads the bank from vreg_wdata_i. A write to any other offset leaves the bank unchanged.
- R7: A read with win_i = 2 (readthrough) uses byte address a = offset + bank*0x2000 + (gfx_half_i ? 0x1000 : 0). It returns the byte at a+1 in bits 15:8 and the byte at a in bits 7:0.
- R8: A write with win_i = 2 is acknowledged but changes no RAM word and issues no ROM access.
- R9: With legacy_i high, both RAM windows map word offset n onto RAM word n.
- R10: win_i = 3 (unmapped) makes no RAM access. A read there returns 0x0000 with rvalid_o.
- R11: After reset, rvalid_o is low and the bank is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write (1) or read (0) |
| win_i | input | 2 | Window: 0 primary, 1 mirror, 2 ROM readthrough, 3 unmapped |
| off_i | input | 12 | Word offset inside the window |
| be_i | input | 2 | Byte strobes |
| wdata_i | input | 16 | Host write data |
| ack_o | output | 1 | Access acknowledge, same cycle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 16 | Read data |
| legacy_i | input | 1 | Linear mapping for both RAM windows |
| gfx_half_i | input | 1 | ROM half select, adds 0x1000 |
| vreg_we_i | input | 1 | Video register write |
| vreg_addr_i | input | 6 | Video register byte offset |
| vreg_wdata_i | input | 4 | Video register bank field data |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 12 | RAM word index |
| ram_be_o | output | 2 | RAM byte strobes |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, one cycle after enable |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr0_o | output | 18 | ROM byte address of the low byte |
| rom_addr1_o | output | 18 | ROM byte address of the high byte |
| rom_byte0_i | input | 8 | ROM byte at rom_addr0_o, one cycle later |
| rom_byte1_i | input | 8 | ROM byte at rom_addr1_o, one cycle later |

## Verification
The RAM and ROM strobes and addresses, and ack_o, depend combinationally on the request. The bench therefore checks them one time step after it drives a request. A RAM write is visible in the bench memory after the next rising edge. Read data and rvalid_o appear one edge after the request, when the memory models and the response register update together. The driver pushes each expected read word into a queue when it issues the read. A monitor, sampling on the falling edge, pops one entry for every rvalid_o pulse, and a missing or extra response is counted as a mismatch. A bank write takes effect at its edge, so the readthrough read that follows it already uses the new bank.

// File: rtl/tile_map_pkg.sv
package tile_map_pkg;
  typedef enum logic [1:0] {
    WIN_PRI  = 2'd0,
    WIN_MIR  = 2'd1,
    WIN_ROM  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;
endpackage

// File: rtl/tile_ram_xlate.sv
module tile_ram_xlate #(
  parameter int OFF_W = 12
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             mirror_i,
  input  logic             legacy_i,
  output logic [OFF_W-1:0] ram_addr_o
);
  logic upper;
  logic parity;
  assign upper  = off_i[OFF_W-1];
  // primary: lower half odd, upper half even; mirror inverts
  assign parity = ~(upper ^ mirror_i);

  always_comb begin
    if (legacy_i) ram_addr_o = off_i;
    else          ram_addr_o = {off_i[OFF_W-2:0], parity};
  end
endmodule

// File: rtl/tile_bank_reg.sv
module tile_bank_reg #(
  parameter int              BANK_W   = 4,
  parameter int              VREG_AW  = 6,
  parameter logic [VREG_AW-1:0] BANK_OFF = 6'h34
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [VREG_AW-1:0] addr_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [BANK_W-1:0]  bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        bank_o <= '0;
    else if (we_i && addr_i == BANK_OFF) bank_o <= wdata_i;
  end
endmodule

// File: rtl/tile_rom_xlate.sv
module tile_rom_xlate #(
  parameter int OFF_W  = 12,
  parameter int BANK_W = 4,
  parameter int ROM_AW = BANK_W + OFF_W + 2
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              half_i,
  output logic [ROM_AW-1:0] addr0_o,
  output logic [ROM_AW-1:0] addr1_o
);
  localparam int          BANK_SH  = OFF_W + 1;
  localparam logic [ROM_AW-1:0] HALF_ADD = ROM_AW'(1) << OFF_W;

  logic [ROM_AW-1:0] base;
  assign base    = ROM_AW'(bank_i) << BANK_SH;
  assign addr0_o = ROM_AW'(off_i) + base + (half_i ? HALF_ADD : '0);
  assign addr1_o = addr0_o + ROM_AW'(1);
endmodule

// File: rtl/tile_map_top.sv
module tile_map_top
  import tile_map_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int DW      = 16,
  parameter int BANK_W  = 4,
  parameter int VREG_AW = 6,
  parameter int ROM_AW  = BANK_W + OFF_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         win_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [DW/8-1:0]    be_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               ack_o,
  output logic               rvalid_o,
  output logic [DW-1:0]      rdata_o,
  input  logic               legacy_i,
  input  logic               gfx_half_i,
  input  logic               vreg_we_i,
  input  logic [VREG_AW-1:0] vreg_addr_i,
  input  logic [BANK_W-1:0]  vreg_wdata_i,
  output logic               ram_en_o,
  output logic               ram_we_o,
  output logic [OFF_W-1:0]   ram_addr_o,
  output logic [DW/8-1:0]    ram_be_o,
  output logic [DW-1:0]      ram_wdata_o,
  input  logic [DW-1:0]      ram_rdata_i,
  output logic               rom_en_o,
  output logic [ROM_AW-1:0]  rom_addr0_o,
  output logic [ROM_AW-1:0]  rom_addr1_o,
  input  logic [DW/2-1:0]    rom_byte0_i,
  input  logic [DW/2-1:0]    rom_byte1_i
);
  win_e              win;
  logic              ram_hit;
  logic [BANK_W-1:0] bank;
  logic              rd_q;
  win_e              src_q;

  assign win     = win_e'(win_i);
  assign ram_hit = req_i && (win == WIN_PRI || win == WIN_MIR);

  tile_ram_xlate #(.OFF_W(OFF_W)) ram_map_i (
    .off_i      (off_i),
    .mirror_i   (win == WIN_MIR),
    .legacy_i   (legacy_i),
    .ram_addr_o (ram_addr_o)
  );

  tile_bank_reg #(.BANK_W(BANK_W), .VREG_AW(VREG_AW)) bank_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vreg_we_i),
    .addr_i  (vreg_addr_i),
    .wdata_i (vreg_wdata_i),
    .bank_o  (bank)
  );

  tile_rom_xlate #(.OFF_W(OFF_W), .BANK_W(BANK_W), .ROM_AW(ROM_AW)) rom_map_i (
    .off_i   (off_i),
    .bank_i  (bank),
    .half_i  (gfx_half_i),
    .addr0_o (rom_addr0_o),
    .addr1_o (rom_addr1_o)
  );

  assign ack_o       = req_i;
  assign ram_en_o    = ram_hit;
  assign ram_we_o    = ram_hit && we_i;
  assign ram_be_o    = be_i;
  assign ram_wdata_o = wdata_i;
  assign rom_en_o    = req_i && !we_i && win == WIN_ROM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      src_q <= WIN_NONE;
    end else begin
      rd_q  <= req_i && !we_i;
      if (req_i && !we_i) src_q <= win;
    end
  end

  assign rvalid_o = rd_q;

  always_comb begin
    rdata_o = '0;
    if (rd_q) begin
      case (src_q)
        WIN_PRI, WIN_MIR: rdata_o = ram_rdata_i;
        WIN_ROM:          rdata_o = {rom_byte1_i, rom_byte0_i};
        default:          rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tile_map_chk.sv
module tile_map_chk #(
  parameter int OFF_W  = 12,
  parameter int ROM_AW = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        win_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [1:0]        be_i,
  input logic [15:0]       wdata_i,
  input logic              legacy_i,
  input logic              rvalid_o,
  input logic              ram_en_o,
  input logic              ram_we_o,
  input logic [OFF_W-1:0]  ram_addr_o,
  input logic [1:0]        ram_be_o,
  input logic [15:0]       ram_wdata_o,
  input logic              rom_en_o,
  input logic [ROM_AW-1:0] rom_addr0_o,
  input logic [ROM_AW-1:0] rom_addr1_o
);
  // R1
  pri_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && win_i == 2'd0 && !legacy_i |-> ram_addr_o[0] == !off_i[OFF_W-1]);
  // R2
  mir_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && win_i == 2'd1 && !legacy_i |-> ram_addr_o[0] == off_i[OFF_W-1]);
  // R4
  strobe_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> ram_be_o == be_i && ram_wdata_o == wdata_i);
  // R5
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
  // R5
  wr_no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i || we_i |=> !rvalid_o);
  // R7
  rom_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> rom_addr1_o == rom_addr0_o + 1'b1);
  // R8
  rom_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win_i == 2'd2 |-> !ram_we_o && !rom_en_o);
  // R9
  legacy_linear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o && legacy_i |-> ram_addr_o == off_i);
  // R10
  none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && win_i == 2'd3 |-> !ram_en_o && !rom_en_o);
endmodule

bind tile_map_top tile_map_chk #(.OFF_W(OFF_W), .ROM_AW(ROM_AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .win_i       (win_i),
  .off_i       (off_i),
  .be_i        (be_i),
  .wdata_i     (wdata_i),
  .legacy_i    (legacy_i),
  .rvalid_o    (rvalid_o),
  .ram_en_o    (ram_en_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .ram_be_o    (ram_be_o),
  .ram_wdata_o (ram_wdata_o),
  .rom_en_o    (rom_en_o),
  .rom_addr0_o (rom_addr0_o),
  .rom_addr1_o (rom_addr1_o)
);

// File: tb/tile_map_top_tb_top.sv
module tile_map_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  win_i = 2'd0;
  logic [11:0] off_i = '0;
  logic [1:0]  be_i = 2'b11;
  logic [15:0] wdata_i = '0;
  logic        ack_o, rvalid_o;
  logic [15:0] rdata_o;
  logic        legacy_i = 1'b0, gfx_half_i = 1'b0;
  logic        vreg_we_i = 1'b0;
  logic [5:0]  vreg_addr_i = '0;
  logic [3:0]  vreg_wdata_i = '0;
  logic        ram_en_o, ram_we_o;
  logic [11:0] ram_addr_o;
  logic [1:0]  ram_be_o;
  logic [15:0] ram_wdata_o;
  logic [15:0] ram_rdata_i;
  logic        rom_en_o;
  logic [17:0] rom_addr0_o, rom_addr1_o;
  logic [7:0]  rom_byte0_i, rom_byte1_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] mem [4096];
  logic [15:0] ref_mem [4096];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  int          bank_m = 0;

  always #5 clk_i = ~clk_i;

  tile_map_top dut_i (.*);

  function automatic logic [7:0] rom_f(input int a);
    int v;
    v = a * 37 + (a >> 8) * 11 + 5;
    return v[7:0];
  endfunction

  // bench models of the RAM and ROM arrays
  always @(posedge clk_i) begin
    if (ram_en_o) begin
      if (ram_we_o) begin
        if (ram_be_o[0]) mem[ram_addr_o][7:0]  <= ram_wdata_o[7:0];
        if (ram_be_o[1]) mem[ram_addr_o][15:8] <= ram_wdata_o[15:8];
      end else ram_rdata_i <= mem[ram_addr_o];
    end
    if (rom_en_o) begin
      rom_byte0_i <= rom_f(int'(rom_addr0_o));
      rom_byte1_i <= rom_f(int'(rom_addr1_o));
    end
  end

  function automatic int map_idx(input int w, input int off);
    if (legacy_i) return off;
    if (w == 0) return (off < 'h800) ? off * 2 + 1 : (off - 'h800) * 2;
    return (off < 'h800) ? off * 2 : (off - 'h800) * 2 + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected rvalid", 1, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_o == e, t, int'(rdata_o), int'(e));
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "watchdog", cyc, 20000);
      report();
    end
  end

  task automatic wr(input int w, input int off, input logic [15:0] d,
                    input logic [1:0] be, input string tag);
    int idx;
    req_i = 1; we_i = 1; win_i = w[1:0]; off_i = off[11:0]; be_i = be; wdata_i = d;
    #1;
    check(ack_o == 1'b1, "R5 ack on write", int'(ack_o), 1);
    if (w >= 2) check(ram_en_o == 1'b0 && rom_en_o == 1'b0, tag, int'(ram_en_o), 0);
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    if (w < 2) begin
      idx = map_idx(w, off);
      if (be[0]) ref_mem[idx][7:0]  = d[7:0];
      if (be[1]) ref_mem[idx][15:8] = d[15:8];
    end
    check(rvalid_o == 1'b0, "R5 no rvalid after write", int'(rvalid_o), 0);
  endtask

  task automatic rd(input int w, input int off, input string tag);
    logic [15:0] e;
    int a;
    if (w < 2) e = ref_mem[map_idx(w, off)];
    else if (w == 2) begin
      a = off + bank_m * 'h2000 + (gfx_half_i ? 'h1000 : 0);
      e = {rom_f(a + 1), rom_f(a)};
    end else e = 16'h0000;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_i = 1; we_i = 0; win_i = w[1:0]; off_i = off[11:0];
    #1;
    check(ack_o == 1'b1, "R5 ack on read", int'(ack_o), 1);
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic vwr(input int addr, input int d);
    vreg_we_i = 1; vreg_addr_i = addr[5:0]; vreg_wdata_i = d[3:0];
    @(negedge clk_i);
    vreg_we_i = 0;
    if (addr == 'h34) bank_m = d;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk_i);
    check(rvalid_o == 1'b0, "R11 rvalid low in reset", int'(rvalid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(rvalid_o == 1'b0, "R11 rvalid low after reset", int'(rvalid_o), 0);
    rd(2, 'h010, "R11 bank zero after reset");

    wr(0, 'h001, 16'h1111, 2'b11, "R1");
    check(mem[3] == 16'h1111, "R1 primary lower to odd word", int'(mem[3]), 'h1111);
    wr(0, 'h805, 16'h2222, 2'b11, "R1");
    check(mem[10] == 16'h2222, "R1 primary upper to even word", int'(mem[10]), 'h2222);
    rd(0, 'h001, "R1 primary read");
    rd(1, 'h801, "R2 mirror upper reaches odd word");
    rd(1, 'h005, "R2 mirror lower reaches even word");

    wr(1, 'h7FF, 16'h3333, 2'b11, "R3");
    check(mem['hFFE] == 16'h3333, "R3 mirror 0x7FF", int'(mem['hFFE]), 'h3333);
    rd(0, 'hFFF, "R3 primary 0xFFF");
    wr(0, 'h7FF, 16'h4444, 2'b11, "R3");
    check(mem['hFFF] == 16'h4444, "R3 primary 0x7FF", int'(mem['hFFF]), 'h4444);
    wr(1, 'h800, 16'h5151, 2'b11, "R3");
    check(mem[1] == 16'h5151, "R3 mirror 0x800", int'(mem[1]), 'h5151);
    rd(0, 'h000, "R3 primary 0x000 to word 1");

    wr(0, 'h002, 16'hABCD, 2'b01, "R4");
    wr(0, 'h002, 16'h5600, 2'b10, "R4");
    check(mem[5] == 16'h56CD, "R4 byte strobes", int'(mem[5]), 'h56CD);
    rd(1, 'h802, "R4 read uses same mapping");
    rd(0, 'h002, "R4 back-to-back read");

    vwr('h34, 3);
    rd(2, 'h010, "R7 bank 3 readthrough");
    gfx_half_i = 1;
    rd(2, 'h010, "R7 half select adds 0x1000");
    vwr('h36, 5);
    rd(2, 'h010, "R6 other offset ignored");
    vwr('h34, 15);
    rd(2, 'hFFF, "R7 top of ROM space");
    gfx_half_i = 0;

    wr(2, 'h003, 16'hDEAD, 2'b11, "R8 no access on ROM write");
    begin
      int diff = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) diff++;
      check(diff == 0, "R8 RAM untouched by ROM write", diff, 0);
    end
    rd(0, 'h003, "R8 primary after ROM write");
    rd(1, 'h003, "R8 mirror after ROM write");

    legacy_i = 1;
    wr(0, 'h020, 16'h7777, 2'b11, "R9");
    check(mem['h20] == 16'h7777, "R9 legacy linear write", int'(mem['h20]), 'h7777);
    rd(1, 'h020, "R9 legacy mirror linear");
    rd(0, 'h805, "R9 legacy primary upper");
    legacy_i = 0;

    rd(3, 'h123, "R10 unmapped read zero");
    wr(3, 'h123, 16'hBEEF, 2'b11, "R10 no access on unmapped write");
    rd(0, 'h005, "R1 primary after unmapped");

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
    report();
  end
endmodule